// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block is the local interrupt interface of one processor in a multi-core cluster. It gathers three kinds of sources into a single ID space. IDs 0 to 31 are this core's private level-sensitive lines. IDs 32 and up are the shared lines that have been routed to this core. IDs 0 to 15 can also be raised by software-generated inter-processor requests. The block keeps an enable bit per ID and an in-service bit per ID. It drives one interrupt request line to the core.

Software uses the block through a small register bus with a one-cycle access. Reading the acknowledge register returns the lowest eligible ID and marks that ID in service. A status register tells software whether another eligible ID is still waiting, so a handler can keep acknowledging until the status bit clears. An end-of-interrupt write retires an ID. Per-ID enables are changed by writing the ID number, not a mask. A write to the request register sends an inter-processor request to other cores. It leaves the block as a one-cycle pulse that carries the request ID and a target-core mask. Matching requests from any core arrive on the ipi_in port.

Top module: `lic_cpu_if`

## Requirements
- R1: After reset the local enable, all per-ID enables, all in-service bits and all software pending bits are clear. irq_req is low, and a read at 0x6C returns 0x3FF.
- R2: A write at 0x000 loads the local enable from data bit 0. A read at 0x000 returns the local enable in bit 0 and zero in all other bits.
- R3: A write at 0x0A0 sets the enable of the ID given in data bits 9:0. A write at 0x0A4 clears it. An ID at or above the number of IDs has no effect. A pending ID whose enable is clear is never selected.
- R4: A read at 0x6C returns, in bits 9:0, the lowest ID that is pending, enabled and not in service. It returns 0x3FF when no ID qualifies. The returned ID is in service from the next cycle. A read that returns 0x3FF changes nothing.
- R5: A read at 0x068 returns bit 31 set exactly when some ID is eligible in the current cycle. All other bits read as zero. After an acknowledge, this bit reflects only the IDs that remain eligible.
- R6: A write at 0x0B4 clears the in-service bit of the ID given in data bits 9:0.
- R7: irq_req is high exactly when the local enable is set and at least one ID is eligible. Acknowledge and status reads work whether or not the local enable is set.
- R8: A write at 0x060 produces, in the next cycle, a one-cycle pulse on ipi_out_vld. The pulse carries data bits 3:0 on ipi_out_id and data bits 15:8 on ipi_out_mask.
- R9: An ipi_in_vld pulse whose mask has bit CPU_ID set makes ID ipi_in_id pending from the next cycle. The bit stays pending until that ID is acknowledged. A pulse that does not target this core has no effect. An arriving request takes precedence over an acknowledge of the same ID in the same cycle.
- R10: Private line n makes ID n pending, and shared line k makes ID 32+k pending, for as long as the line is high.
- R11: An ID that is in service is not selected again until its end-of-interrupt write, even if its line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_irq | input | 32 | Private level lines, IDs 0 to 31 |
| shr_irq | input | N_SHR | Routed shared level lines, IDs 32 and up |
| ipi_in_vld | input | 1 | Inter-processor request from any core |
| ipi_in_id | input | 4 | ID of the incoming request |
| ipi_in_mask | input | N_CPU | Target cores of the incoming request |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_req | output | 1 | Interrupt request to the core |
| ipi_out_vld | output | 1 | Outgoing inter-processor request pulse |
| ipi_out_id | output | 4 | Outgoing request ID |
| ipi_out_mask | output | N_CPU | Outgoing target-core mask |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- Acknowledging several IDs in a row, then reading the status bit. A design that computed the status from stale state would report a pending ID that was already taken.
- Keeping a line high after its acknowledge. A design that ignored the in-service set would return the same ID twice before its end-of-interrupt.
- Clear-enable writes with IDs just above the ID range. A design that truncated the ID would disable a low ID by aliasing.
- Software requests that do not target this core. A design that mis-decoded the mask would raise them anyway.
- Software requests that race an acknowledge of the same ID. A design that let the clear win would lose a request.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned LIC_IDW   = 10;
  localparam logic [LIC_IDW-1:0] LIC_NONE = 10'h3FF;
  localparam int unsigned LIC_PRIV  = 32;
  localparam int unsigned LIC_SGI   = 16;

  localparam logic [11:0] OFS_CTRL = 12'h000;
  localparam logic [11:0] OFS_IPI  = 12'h060;
  localparam logic [11:0] OFS_STAT = 12'h068;
  localparam logic [11:0] OFS_ACK  = 12'h06C;
  localparam logic [11:0] OFS_SETE = 12'h0A0;
  localparam logic [11:0] OFS_CLRE = 12'h0A4;
  localparam logic [11:0] OFS_EOI  = 12'h0B4;

  function automatic logic [31:0] status_word(input logic any_elig);
    return {any_elig, 31'b0};
  endfunction

  function automatic logic [31:0] ack_word(input logic [LIC_IDW-1:0] id);
    return {{(32-LIC_IDW){1'b0}}, id};
  endfunction

  function automatic logic [31:0] ctrl_word(input logic en);
    return {31'b0, en};
  endfunction
endpackage

// File: rtl/lic_pick.sv
module lic_pick
  import lic_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic [N-1:0]         elig,
  output logic                 found,
  output logic [LIC_IDW-1:0]   best
);
  always_comb begin
    found = 1'b0;
    best  = LIC_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        best  = LIC_IDW'(i);
      end
    end
  end
endmodule

// File: rtl/lic_state.sv
module lic_state
  import lic_pkg::*;
#(
  parameter int unsigned N      = 64,
  parameter int unsigned N_CPU  = 8,
  parameter int unsigned CPU_ID = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en_v,
  input  logic                 clr_en_v,
  input  logic                 ack_v,
  input  logic                 eoi_v,
  input  logic [LIC_IDW-1:0]   op_id,
  input  logic                 ipi_in_vld,
  input  logic [3:0]           ipi_in_id,
  input  logic [N_CPU-1:0]     ipi_in_mask,
  output logic [N-1:0]         en_mask,
  output logic [N-1:0]         in_svc,
  output logic [LIC_SGI-1:0]   sgi_pend
);
  localparam int unsigned IW = $clog2(N);

  logic              id_ok;
  logic [IW-1:0]     op_idx;
  logic [N-1:0]      id_oh;
  logic              ipi_hit;
  logic [LIC_SGI-1:0] sgi_set, sgi_clr;

  assign id_ok   = op_id < LIC_IDW'(N);
  assign op_idx  = op_id[IW-1:0];
  assign id_oh   = id_ok ? ({{(N-1){1'b0}}, 1'b1} << op_idx) : '0;
  assign ipi_hit = ipi_in_vld && ipi_in_mask[CPU_ID];
  assign sgi_set = ipi_hit ? (LIC_SGI'(1) << ipi_in_id) : '0;
  assign sgi_clr = (ack_v && op_id < LIC_IDW'(LIC_SGI)) ? (LIC_SGI'(1) << op_id[3:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask  <= '0;
      in_svc   <= '0;
      sgi_pend <= '0;
    end else begin
      en_mask  <= (en_mask | (set_en_v ? id_oh : '0)) & ~(clr_en_v ? id_oh : '0);
      in_svc   <= (in_svc  | (ack_v    ? id_oh : '0)) & ~(eoi_v    ? id_oh : '0);
      sgi_pend <= (sgi_pend & ~sgi_clr) | sgi_set;
    end
  end

  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_v && id_ok) |=> en_mask[$past(op_idx)]);
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_v && id_ok) |=> !en_mask[$past(op_idx)]);
  a_r4_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_v && id_ok) |=> in_svc[$past(op_idx)]);
  a_r6_eoi_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_v && id_ok) |=> !in_svc[$past(op_idx)]);
  a_r9_ipi_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_hit |=> sgi_pend[$past(ipi_in_id)]);
endmodule

// File: rtl/lic_cpu_if.sv
module lic_cpu_if
  import lic_pkg::*;
#(
  parameter int unsigned N_SHR  = 32,
  parameter int unsigned N_CPU  = 8,
  parameter int unsigned CPU_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        priv_irq,
  input  logic [N_SHR-1:0]   shr_irq,
  input  logic               ipi_in_vld,
  input  logic [3:0]         ipi_in_id,
  input  logic [N_CPU-1:0]   ipi_in_mask,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_req,
  output logic               ipi_out_vld,
  output logic [3:0]         ipi_out_id,
  output logic [N_CPU-1:0]   ipi_out_mask
);
  localparam int unsigned N = LIC_PRIV + N_SHR;

  logic               ctrl_en;
  logic [N-1:0]       en_mask, in_svc, pend, elig;
  logic [LIC_SGI-1:0] sgi_pend;
  logic               found;
  logic [LIC_IDW-1:0] best, op_id;
  logic               wr_ctrl, wr_ipi, wr_set, wr_clr, wr_eoi, ack_v;
  logic               unused_bits;

  assign wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
  assign wr_ipi  = bus_wr && bus_addr == OFS_IPI;
  assign wr_set  = bus_wr && bus_addr == OFS_SETE;
  assign wr_clr  = bus_wr && bus_addr == OFS_CLRE;
  assign wr_eoi  = bus_wr && bus_addr == OFS_EOI;
  assign ack_v   = bus_rd && bus_addr == OFS_ACK && found;
  assign op_id   = ack_v ? best : bus_wdata[LIC_IDW-1:0];

  assign pend = {shr_irq, priv_irq | {{(LIC_PRIV-LIC_SGI){1'b0}}, sgi_pend}};
  assign elig = pend & en_mask & ~in_svc;

  lic_state #(.N(N), .N_CPU(N_CPU), .CPU_ID(CPU_ID)) u_state (
    .clk(clk), .rst_n(rst_n),
    .set_en_v(wr_set), .clr_en_v(wr_clr), .ack_v(ack_v), .eoi_v(wr_eoi),
    .op_id(op_id),
    .ipi_in_vld(ipi_in_vld), .ipi_in_id(ipi_in_id), .ipi_in_mask(ipi_in_mask),
    .en_mask(en_mask), .in_svc(in_svc), .sgi_pend(sgi_pend)
  );

  lic_pick #(.N(N)) u_pick (.elig(elig), .found(found), .best(best));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en      <= 1'b0;
      ipi_out_vld  <= 1'b0;
      ipi_out_id   <= '0;
      ipi_out_mask <= '0;
    end else begin
      if (wr_ctrl) ctrl_en <= bus_wdata[0];
      ipi_out_vld <= wr_ipi;
      if (wr_ipi) begin
        ipi_out_id   <= bus_wdata[3:0];
        ipi_out_mask <= bus_wdata[8 +: N_CPU];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_word(ctrl_en);
      OFS_STAT: bus_rdata = status_word(found);
      OFS_ACK:  bus_rdata = ack_word(best);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_req = ctrl_en && found;

  assign unused_bits = ^{bus_wdata[31:16], ipi_in_mask};

  a_r4_best_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> elig[best[$clog2(N)-1:0]]);
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ctrl_en && elig != '0));
  a_r8_ipi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ipi |=> (ipi_out_vld && ipi_out_id == $past(bus_wdata[3:0])));
  a_r11_no_reselect: assert property (@(posedge clk) disable iff (!rst_n)
    ack_v |=> !(found && best == $past(best) && !$past(wr_eoi)));
endmodule

// File: tb/sim_lic_cpu_if.sv
module sim_lic_cpu_if;
  localparam int N_SHR = 32;
  localparam int N_CPU = 8;
  localparam int ME    = 2;
  localparam int NID   = 32 + N_SHR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] priv_irq = '0;
  logic [N_SHR-1:0] shr_irq = '0;
  logic ipi_in_vld = 1'b0;
  logic [3:0] ipi_in_id = '0;
  logic [N_CPU-1:0] ipi_in_mask = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_req, ipi_out_vld;
  logic [3:0] ipi_out_id;
  logic [N_CPU-1:0] ipi_out_mask;

  always #10 clk = ~clk;

  lic_cpu_if #(.N_SHR(N_SHR), .N_CPU(N_CPU), .CPU_ID(ME)) u0 (
    .clk(clk), .rst_n(rst_n), .priv_irq(priv_irq), .shr_irq(shr_irq),
    .ipi_in_vld(ipi_in_vld), .ipi_in_id(ipi_in_id), .ipi_in_mask(ipi_in_mask),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .ipi_out_vld(ipi_out_vld),
    .ipi_out_id(ipi_out_id), .ipi_out_mask(ipi_out_mask)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit m_en;
  bit m_mask[NID];
  bit m_svc[NID];
  bit m_sgi[16];
  bit x_ipi;
  int x_ipi_id, x_ipi_mask;

  function automatic bit m_pend(int i);
    if (i < 32) return priv_irq[i] || (i < 16 && m_sgi[i]);
    return shr_irq[i-32];
  endfunction

  function automatic int m_best();
    for (int i = 0; i < NID; i++)
      if (m_pend(i) && m_mask[i] && !m_svc[i]) return i;
    return 'h3FF;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_en = 0; x_ipi = 0; x_ipi_id = 0; x_ipi_mask = 0;
    for (int i = 0; i < NID; i++) begin m_mask[i] = 0; m_svc[i] = 0; end
    for (int i = 0; i < 16; i++) m_sgi[i] = 0;
  endtask

  // one bus cycle: inputs already driven after a falling edge
  task automatic tick();
    int b, id;
    #5;
    b = m_best();
    chk("R7", "irq_req", irq_req, (m_en && b != 'h3FF));
    chk("R8", "ipi_out_vld", ipi_out_vld, x_ipi);
    if (x_ipi) begin
      chk("R8", "ipi_out_id", ipi_out_id, x_ipi_id);
      chk("R8", "ipi_out_mask", ipi_out_mask, x_ipi_mask);
    end
    if (bus_rd) begin
      case (bus_addr)
        12'h000: chk("R2", "ctrl read", bus_rdata, {31'b0, m_en});
        12'h068: chk("R5", "status read", bus_rdata, (b != 'h3FF) ? 32'h8000_0000 : 32'h0);
        12'h06C: chk("R4", "ack read", bus_rdata, b);
        default: ;
      endcase
    end
    @(posedge clk);
    id = int'(bus_wdata[9:0]);
    if (bus_wr) begin
      case (bus_addr)
        12'h000: m_en = bus_wdata[0];
        12'h0A0: if (id < NID) m_mask[id] = 1;
        12'h0A4: if (id < NID) m_mask[id] = 0;
        12'h0B4: if (id < NID) m_svc[id] = 0;
        default: ;
      endcase
    end
    x_ipi = bus_wr && bus_addr == 12'h060;
    if (x_ipi) begin x_ipi_id = int'(bus_wdata[3:0]); x_ipi_mask = int'(bus_wdata[15:8]); end
    if (bus_rd && bus_addr == 12'h06C && b != 'h3FF) begin
      m_svc[b] = 1;
      if (b < 16) m_sgi[b] = 0;
    end
    if (ipi_in_vld && ipi_in_mask[ME]) m_sgi[ipi_in_id] = 1;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    ipi_in_vld = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
  endtask

  task automatic rd(logic [11:0] a);
    bus_rd = 1; bus_addr = a; tick();
  endtask

  task automatic ipi_in(int id, int mask);
    ipi_in_vld = 1; ipi_in_id = 4'(id); ipi_in_mask = N_CPU'(mask); tick();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq after reset", irq_req, 0);
    rd(12'h06C);
    rd(12'h000);
    rd(12'h068);
    // R2 local enable
    wr(12'h000, 32'h1);
    rd(12'h000);
    // R3 line pending but not enabled, R10 private line
    priv_irq[5] = 1;
    rd(12'h06C);
    wr(12'h0A0, 32'd5);
    rd(12'h068);
    rd(12'h06C);          // R4 returns 5
    rd(12'h068);          // R5 now clear
    rd(12'h06C);          // R11 not re-selected
    wr(12'h0B4, 32'd5);   // R6
    rd(12'h068);
    wr(12'h0A4, 32'd5);
    rd(12'h06C);
    // R4/R10 ordering across private and shared IDs
    shr_irq[1] = 1; shr_irq[8] = 1; priv_irq[7] = 1;
    wr(12'h0A0, 32'd40); wr(12'h0A0, 32'd33); wr(12'h0A0, 32'd7);
    rd(12'h06C); rd(12'h068); rd(12'h06C); rd(12'h068); rd(12'h06C); rd(12'h068); rd(12'h06C);
    wr(12'h0B4, 32'd33); rd(12'h06C);
    wr(12'h0B4, 32'd7); wr(12'h0B4, 32'd40);
    // R3 out-of-range clear must not alias onto ID 7
    wr(12'h0A4, 32'd71);
    wr(12'h0A4, 32'd64 + 32'd7 + 32'd64);
    chk("R3", "irq kept after out-of-range clear", irq_req, 1);
    rd(12'h06C);
    wr(12'h0B4, 32'd7);
    wr(12'h0A4, 32'd7); wr(12'h0A4, 32'd33); wr(12'h0A4, 32'd40);
    priv_irq = '0; shr_irq = '0;
    // R8 outgoing request
    wr(12'h060, 32'h0000_0C0F);
    tick();
    wr(12'h060, 32'hFFFF_A503);
    // R9 incoming request
    wr(12'h0A0, 32'd15);
    ipi_in(15, 8'h01);    // not for this core
    rd(12'h06C);
    ipi_in(15, 8'h04);
    rd(12'h068);
    rd(12'h06C);
    wr(12'h0B4, 32'd15);
    rd(12'h06C);          // cleared on acknowledge
    ipi_in(15, 8'hFF);
    ipi_in_vld = 1; ipi_in_id = 4'd15; ipi_in_mask = 8'h04;
    bus_rd = 1; bus_addr = 12'h06C; tick();   // set wins over clear
    wr(12'h0B4, 32'd15);
    rd(12'h068);
    rd(12'h06C);
    wr(12'h0B4, 32'd15);
    // R7 local enable off: no request, acknowledge still works
    priv_irq[3] = 1; wr(12'h0A0, 32'd3);
    wr(12'h000, 32'h0);
    chk("R7", "irq gated by local enable", irq_req, 0);
    rd(12'h06C);
    wr(12'h0B4, 32'd3);
    wr(12'h000, 32'h1);
    // mixed random traffic against the model
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 9);
      priv_irq = $urandom; shr_irq = N_SHR'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        ipi_in_vld = 1; ipi_in_id = 4'($urandom); ipi_in_mask = N_CPU'($urandom);
      end
      case (op)
        0: wr(12'h0A0, 32'($urandom_range(0, 70)));
        1: wr(12'h0A4, 32'($urandom_range(0, 70)));
        2: wr(12'h0B4, 32'($urandom_range(0, 63)));
        3, 4: rd(12'h06C);
        5: rd(12'h068);
        6: wr(12'h060, $urandom);
        7: wr(12'h000, 32'($urandom_range(0, 1)));
        8: rd(12'h000);
        default: tick();
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule